// File: doc/BRIEF.md
# Seventeen-Row Carry-Save Compressor Tree

This block adds seventeen equally wide rows into one result of the same width. It is the summing half of a radix-4 recoded multiplier. The recoding stage, which sits outside this block, delivers the rows already shifted into place and sign-extended, with any negate-correction bits folded in. The tree returns their total, with carries past the top bit discarded.

The reduction follows a fixed schedule. Two levels of 3-2 cells take the seventeen rows down to twelve, and then to eight. Two levels of 4-2 cells then take the eight rows down to four, and then to two. A two-input adder forms the result. The block is purely combinational, so the result belongs to the input vector presented in the same cycle. There are no states, no clock and no reset. Pipeline registers, where they are needed, belong to the surrounding datapath.

Top module: `ct_tree17`

## Requirements
- R1: For every input vector, `prod_o` equals the sum of the seventeen `W`-bit rows modulo 2^W. It depends only on the current inputs, with no register on the path.
- R2: When a single row holds a non-zero value and all other rows are zero, that value appears unchanged at `prod_o`. This holds for every row index 0 to 16, including rows 15 and 16, which bypass the first level. Row k occupies bits [k*W+W-1 : k*W] of `rows_i`.
- R3: The first 3-2 level groups rows 0-14 in triples and passes rows 15 and 16 through, giving twelve rows. The second level groups those twelve in triples, giving eight. Each level preserves the total modulo 2^W.
- R4: Two levels of 4-2 cells reduce eight rows to four and then four rows to two. Each level preserves the total modulo 2^W.
- R5: Inside a 4-2 cell, the lateral carry sent to the next column up depends only on three of the four bits of its own column and never on the incoming lateral carry. Carry chains across the full width therefore still give the exact sum.
- R6: Carries out of bit W-1 are dropped. Rows whose true sum exceeds 2^W-1 produce the low W bits of that sum.
- R7: Seventeen rows of all ones produce 2^W-17.
- R8: All rows zero produce zero.
- R9: Rows holding two's-complement negative values combine correctly. A row and its negation cancel to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rows_i | input | 17*W | Seventeen partial-product rows, row k at bits [k*W+W-1 : k*W] |
| prod_o | output | W | Sum of all rows modulo 2^W |

## Verification
Every result is due in the same cycle as its stimulus, because the path from `rows_i` to `prod_o` holds no register. The bench drives each vector on the falling clock edge and waits half of the low phase before comparing. This lets the combinational network settle, and the sample is still taken before the next rising edge. Each expected value comes from a bench-side loop that adds the seventeen rows in W-bit arithmetic. Directed vectors cover single rows, carry chains, wrap-around and cancellation, and random vectors follow.

// File: rtl/ct_pkg.sv
package ct_pkg;
    localparam int CT_ROWS      = 17;
    localparam int CT_L1_CELLS  = 5;
    localparam int CT_L1_PASS   = CT_ROWS - 3 * CT_L1_CELLS;
    localparam int CT_L1_ROWS   = 2 * CT_L1_CELLS + CT_L1_PASS;
    localparam int CT_L2_CELLS  = CT_L1_ROWS / 3;
    localparam int CT_L2_ROWS   = 2 * CT_L2_CELLS;
    localparam int CT_L3_CELLS  = CT_L2_ROWS / 4;
    localparam int CT_L3_ROWS   = 2 * CT_L3_CELLS;
    localparam int CT_L4_ROWS   = 2;
endpackage

// File: rtl/ct_csa_row.sv
module ct_csa_row #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    logic [W-1:0] maj;

    assign sum_o   = a_i ^ b_i ^ c_i;
    assign maj     = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
    assign carry_o = {maj[W-2:0], 1'b0};

    // R3: each 3-2 cell keeps the three-row total modulo 2^W
    always_comb begin
        assert_csa_conserves_R3: assert ((sum_o + carry_o) == (a_i + b_i + c_i))
            else $error("3-2 row lost value");
    end
endmodule

// File: rtl/ct_cmp42_row.sv
module ct_cmp42_row #(
    parameter int W = 64
) (
    input  logic [W-1:0] x0_i,
    input  logic [W-1:0] x1_i,
    input  logic [W-1:0] x2_i,
    input  logic [W-1:0] x3_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    logic [W-1:0] part;
    logic [W-1:0] lat_out;
    logic [W-1:0] lat_in;
    logic [W-1:0] upper;

    // first adder of each column: three own bits, lateral carry out (R5)
    assign part    = x0_i ^ x1_i ^ x2_i;
    assign lat_out = (x0_i & x1_i) | (x0_i & x2_i) | (x1_i & x2_i);
    assign lat_in  = {lat_out[W-2:0], 1'b0};

    // second adder: partial sum, fourth bit, lateral carry in
    assign sum_o   = part ^ x3_i ^ lat_in;
    assign upper   = (part & x3_i) | (part & lat_in) | (x3_i & lat_in);
    assign carry_o = {upper[W-2:0], 1'b0};

    // R4: each 4-2 row keeps the four-row total modulo 2^W
    always_comb begin
        assert_cmp42_conserves_R4: assert ((sum_o + carry_o) == (x0_i + x1_i + x2_i + x3_i))
            else $error("4-2 row lost value");
    end
endmodule

// File: rtl/ct_final_add.sv
module ct_final_add #(
    parameter int W = 64
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    assign sum_o = a_i + b_i;
endmodule

// File: rtl/ct_tree17.sv
module ct_tree17
    import ct_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [CT_ROWS*W-1:0] rows_i,
    output logic [W-1:0]         prod_o
);
    logic [W-1:0] lv0 [CT_ROWS];
    logic [W-1:0] lv1 [CT_L1_ROWS];
    logic [W-1:0] lv2 [CT_L2_ROWS];
    logic [W-1:0] lv3 [CT_L3_ROWS];
    logic [W-1:0] lv4 [CT_L4_ROWS];

    for (genvar k = 0; k < CT_ROWS; k++) begin : g_unpack
        assign lv0[k] = rows_i[k*W +: W];
    end

    // level 1: five 3-2 cells on rows 0..14, rows 15 and 16 bypass
    for (genvar g = 0; g < CT_L1_CELLS; g++) begin : g_lvl1
        ct_csa_row #(.W(W)) u_csa (
            .a_i    (lv0[3*g]),
            .b_i    (lv0[3*g+1]),
            .c_i    (lv0[3*g+2]),
            .sum_o  (lv1[2*g]),
            .carry_o(lv1[2*g+1])
        );
    end
    for (genvar p = 0; p < CT_L1_PASS; p++) begin : g_bypass
        assign lv1[2*CT_L1_CELLS+p] = lv0[3*CT_L1_CELLS+p];
    end

    // level 2: four 3-2 cells, twelve rows to eight
    for (genvar g = 0; g < CT_L2_CELLS; g++) begin : g_lvl2
        ct_csa_row #(.W(W)) u_csa (
            .a_i    (lv1[3*g]),
            .b_i    (lv1[3*g+1]),
            .c_i    (lv1[3*g+2]),
            .sum_o  (lv2[2*g]),
            .carry_o(lv2[2*g+1])
        );
    end

    // level 3: two 4-2 rows, eight to four
    for (genvar g = 0; g < CT_L3_CELLS; g++) begin : g_lvl3
        ct_cmp42_row #(.W(W)) u_c42 (
            .x0_i   (lv2[4*g]),
            .x1_i   (lv2[4*g+1]),
            .x2_i   (lv2[4*g+2]),
            .x3_i   (lv2[4*g+3]),
            .sum_o  (lv3[2*g]),
            .carry_o(lv3[2*g+1])
        );
    end

    // level 4: one 4-2 row, four to two
    ct_cmp42_row #(.W(W)) u_lvl4 (
        .x0_i   (lv3[0]),
        .x1_i   (lv3[1]),
        .x2_i   (lv3[2]),
        .x3_i   (lv3[3]),
        .sum_o  (lv4[0]),
        .carry_o(lv4[1])
    );

    ct_final_add #(.W(W)) u_cpa (
        .a_i  (lv4[0]),
        .b_i  (lv4[1]),
        .sum_o(prod_o)
    );

    // level totals against the input total
    logic [W-1:0] tot_in;
    logic [W-1:0] tot_l1;
    logic [W-1:0] tot_l2;
    logic [W-1:0] tot_l3;

    always_comb begin
        tot_in = '0;
        for (int k = 0; k < CT_ROWS; k++) tot_in = tot_in + lv0[k];
        tot_l1 = '0;
        for (int k = 0; k < CT_L1_ROWS; k++) tot_l1 = tot_l1 + lv1[k];
        tot_l2 = '0;
        for (int k = 0; k < CT_L2_ROWS; k++) tot_l2 = tot_l2 + lv2[k];
        tot_l3 = '0;
        for (int k = 0; k < CT_L3_ROWS; k++) tot_l3 = tot_l3 + lv3[k];
    end

    always_comb begin
        assert_lvl1_total_R3: assert (tot_l1 == tot_in)
            else $error("level 1 total differs");
        assert_lvl2_total_R3: assert (tot_l2 == tot_in)
            else $error("level 2 total differs");
        assert_lvl3_total_R4: assert (tot_l3 == tot_in)
            else $error("level 3 total differs");
        assert_product_R1: assert (prod_o == tot_in)
            else $error("product differs from row total");
    end
endmodule

// File: tb/ct_tree17_bench.sv
module ct_tree17_bench;
    localparam int W    = 64;
    localparam int ROWS = 17;

    logic                 clk = 1'b0;
    logic [ROWS*W-1:0]    rows;
    logic [W-1:0]         prod;
    int                   n_vec  = 0;
    int                   n_fail = 0;
    logic [31:0]          seed   = 32'h1D2C_3B4A;

    always #10 clk = ~clk;

    ct_tree17 #(.W(W)) u_ct_tree17 (
        .rows_i(rows),
        .prod_o(prod)
    );

    function automatic logic [W-1:0] ref_total(input logic [ROWS*W-1:0] v);
        logic [W-1:0] acc = '0;
        for (int k = 0; k < ROWS; k++) acc = acc + v[k*W +: W];
        return acc;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    task automatic apply(input logic [ROWS*W-1:0] v, input string tag);
        logic [W-1:0] exp;
        @(negedge clk);
        rows = v;
        #5;
        exp = ref_total(v);
        n_vec++;
        if (prod !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, prod, exp);
        end
    endtask

    task automatic t_zero();
        apply('0, "R8 all zero");
    endtask

    task automatic t_single_row();
        for (int k = 0; k < ROWS; k++) begin
            logic [ROWS*W-1:0] v = '0;
            v[k*W +: W] = 64'h0123_4567_89AB_CDEF ^ (64'(k) << 40) ^ 64'(k);
            apply(v, "R2 single row");
        end
    endtask

    task automatic t_all_ones();
        apply({ROWS*W{1'b1}}, "R7 all ones");
    endtask

    task automatic t_wrap();
        logic [ROWS*W-1:0] v = '0;
        for (int k = 0; k < ROWS; k++) v[k*W +: W] = 64'h8000_0000_0000_0001;
        apply(v, "R6 top bit wrap");
        v = '0;
        v[0 +: W] = '1;
        v[16*W +: W] = 64'd1;
        apply(v, "R6 overflow to zero");
    endtask

    task automatic t_cancel();
        logic [ROWS*W-1:0] v = '0;
        v[3*W +: W]  = 64'h0000_1234_5678_9ABC;
        v[15*W +: W] = -64'h0000_1234_5678_9ABC;
        apply(v, "R9 row and negation cancel");
        v = '0;
        for (int k = 0; k < ROWS; k++) v[k*W +: W] = -64'(k + 1);
        apply(v, "R9 negative rows");
    endtask

    task automatic t_carry_chain();
        logic [ROWS*W-1:0] v = '0;
        for (int k = 0; k < ROWS; k++)
            v[k*W +: W] = k[0] ? 64'h5555_5555_5555_5555 : 64'hAAAA_AAAA_AAAA_AAAA;
        apply(v, "R5 alternating patterns");
        v = '0;
        for (int k = 0; k < 8; k++) v[k*W +: W] = '1;
        v[8*W +: W] = 64'd8;
        apply(v, "R5 long carry chain");
    endtask

    task automatic t_levels();
        logic [ROWS*W-1:0] v = '0;
        for (int k = 0; k < 15; k++) v[k*W +: W] = 64'h0F0F_F0F0_0F0F_F0F0;
        apply(v, "R3 first level triples only");
        v = '0;
        v[15*W +: W] = 64'hFFFF_0000_FFFF_0000;
        v[16*W +: W] = 64'h0001_0000_0001_0000;
        apply(v, "R3 bypass rows only");
        v = '0;
        for (int k = 0; k < 12; k++) v[k*W +: W] = 64'(k) * 64'h1111_1111_1111_1111;
        apply(v, "R4 four-two levels");
    endtask

    task automatic t_random();
        for (int n = 0; n < 300; n++) begin
            logic [ROWS*W-1:0] v;
            for (int k = 0; k < ROWS; k++) begin
                logic [31:0] hi;
                seed = step(seed);
                hi   = seed;
                seed = step(seed);
                v[k*W +: W] = {hi, seed};
            end
            apply(v, "R1 random rows");
        end
    endtask

    initial begin
        rows = '0;
        #15;
        t_zero();
        t_single_row();
        t_all_ones();
        t_wrap();
        t_cancel();
        t_carry_chain();
        t_levels();
        t_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #5_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule